// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with Annulling Delay Slot

This unit settles conditional branches while they sit in the decode stage of a five-stage pipeline. It does not wait for the execute stage. The branch condition compares one source register with zero, and there are two branch kinds: taken when the register is zero, and taken when it is nonzero. The unit has its own adder that forms the branch target. At the same time it forms the sequential addresses. The main ALU is therefore never needed.

The unit owns the fetch PC register. Each branch in decode carries a delay flag. A branch without the flag redirects fetch and requests one bubble, which discards the instruction fetched behind it. A branch with the flag lets the next instruction (the delay slot) run. A delayed branch may also set an annul flag and a predicted direction. If the predicted direction turns out wrong, the unit marks the delay-slot instruction as annulled, so that it behaves as a no-op.

The three outputs are registered and describe the cycle after the branch was in decode:
- `fetch_pc` is the address being fetched in that cycle.
- `bubble` and `slot_kill` say that the instruction which entered decode at the redirecting edge must be dropped.

Top module: `dslot_branch_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `fetch_pc` equals RESET_PC and both `bubble` and `slot_kill` are 0.
- R2: A cycle with no valid branch in decode (`id_valid`=0 or `id_is_branch`=0) advances `fetch_pc` by 4 and leaves `bubble` and `slot_kill` at 0 in the next cycle. All other branch inputs have no effect in such a cycle.
- R3: With `id_test_nz`=0 the branch is taken exactly when `id_rs_val` is zero. With `id_test_nz`=1 it is taken exactly when `id_rs_val` is nonzero.
- R4: The taken target is `id_pc` + 4 + (sign-extended `id_offset` shifted left by 2), taken modulo 2^AW.
- R5: A valid branch with `id_delayed`=0 sets `fetch_pc` to the target when taken and to `id_pc`+4 when not taken. It raises `bubble` for one cycle and keeps `slot_kill` at 0.
- R6: A valid branch with `id_delayed`=1 sets `fetch_pc` to the target when taken and to `id_pc`+8 when not taken, with `bubble` at 0. When `id_annul`=0 in this case, `slot_kill` stays 0.
- R7: A valid branch with `id_delayed`=1 and `id_annul`=1 raises `slot_kill` for one cycle exactly when the actual outcome differs from `id_pred_taken` (1 means predicted taken).
- R8: When `id_delayed`=0, the flags `id_annul` and `id_pred_taken` change none of the outputs.
- R9: `bubble` and `slot_kill` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode slot holds a live instruction |
| id_is_branch | input | 1 | Decoded instruction is a conditional branch |
| id_test_nz | input | 1 | 0: taken when zero, 1: taken when nonzero |
| id_delayed | input | 1 | Branch has an architectural delay slot |
| id_annul | input | 1 | Delay slot is cancelled on a misprediction |
| id_pred_taken | input | 1 | Predicted direction for the annul check |
| id_rs_val | input | XLEN | Source register value |
| id_pc | input | AW | Address of the branch |
| id_offset | input | OFFW | Word offset relative to the slot address |
| fetch_pc | output | AW | Registered fetch address |
| bubble | output | 1 | Drop the instruction that entered decode (non-delayed branch) |
| slot_kill | output | 1 | Annul the delay-slot instruction that entered decode |

## Verification
The sweep takes every mode combination, including annul and prediction flags set on non-delayed branches. It crosses these with both test kinds and register values of zero, one, all-ones and the most negative value, so that each zero/nonzero decision is seen from both sides.
- Offsets of zero, plus and minus one, and the two extremes of the field check that the sign extension and the shift are right.
- Both prediction values meet both actual outcomes, which separates an annul on misprediction from an annul that is always on or never on.
- Idle and invalid-branch cycles with branch-like inputs confirm that only a live branch redirects fetch.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  // How the branch in decode (if any) steers fetch.
  typedef enum logic [1:0] {
    SEQ_NEXT  = 2'd0,  // no live branch
    BR_STALL  = 2'd1,  // resolved branch, one bubble
    BR_DELAY  = 2'd2,  // delay slot always runs
    BR_CANCEL = 2'd3   // delay slot annulled on misprediction
  } dsb_mode_e;

  function automatic dsb_mode_e pick_mode(input logic live, input logic delayed,
                                          input logic annul);
    if (!live)         return SEQ_NEXT;
    else if (!delayed) return BR_STALL;
    else if (annul)    return BR_CANCEL;
    else               return BR_DELAY;
  endfunction
endpackage

// File: rtl/dsb_zero_test.sv
module dsb_zero_test #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] rs_val,
  input  logic            test_nz,
  output logic            cond_taken
);
  logic is_zero;
  assign is_zero    = (rs_val == '0);
  assign cond_taken = test_nz ? !is_zero : is_zero;
endmodule

// File: rtl/dsb_target_add.sv
module dsb_target_add #(
  parameter int AW   = 32,
  parameter int OFFW = 16
) (
  input  logic [AW-1:0]   br_pc,
  input  logic [OFFW-1:0] offset,
  output logic [AW-1:0]   slot_pc,
  output logic [AW-1:0]   after_pc,
  output logic [AW-1:0]   target_pc
);
  localparam int SHW = OFFW + 2;
  logic [AW-1:0] disp;

  generate
    if (AW > SHW) begin : g_extend
      assign disp = {{(AW-SHW){offset[OFFW-1]}}, offset, 2'b00};
    end else begin : g_trunc
      logic [SHW-1:0] wide;
      assign wide = {offset, 2'b00};
      assign disp = wide[AW-1:0];
    end
  endgenerate

  assign slot_pc   = br_pc + AW'(4);
  assign after_pc  = br_pc + AW'(8);
  assign target_pc = slot_pc + disp;
endmodule

// File: rtl/dsb_redirect.sv
module dsb_redirect
  import dsb_pkg::*;
#(
  parameter int AW = 32
) (
  input  dsb_mode_e     mode,
  input  logic          taken,
  input  logic          pred_taken,
  input  logic [AW-1:0] cur_fetch,
  input  logic [AW-1:0] slot_pc,
  input  logic [AW-1:0] after_pc,
  input  logic [AW-1:0] target_pc,
  output logic [AW-1:0] nxt_fetch,
  output logic          nxt_bubble,
  output logic          nxt_kill
);
  always_comb begin
    nxt_fetch  = cur_fetch + AW'(4);
    nxt_bubble = 1'b0;
    nxt_kill   = 1'b0;
    case (mode)
      BR_STALL: begin
        nxt_fetch  = taken ? target_pc : slot_pc;
        nxt_bubble = 1'b1;
      end
      BR_DELAY: begin
        nxt_fetch = taken ? target_pc : after_pc;
      end
      BR_CANCEL: begin
        nxt_fetch = taken ? target_pc : after_pc;
        nxt_kill  = (taken != pred_taken);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dslot_branch_unit.sv
module dslot_branch_unit
  import dsb_pkg::*;
#(
  parameter int            XLEN     = 32,
  parameter int            AW       = 32,
  parameter int            OFFW     = 16,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            id_valid,
  input  logic            id_is_branch,
  input  logic            id_test_nz,
  input  logic            id_delayed,
  input  logic            id_annul,
  input  logic            id_pred_taken,
  input  logic [XLEN-1:0] id_rs_val,
  input  logic [AW-1:0]   id_pc,
  input  logic [OFFW-1:0] id_offset,
  output logic [AW-1:0]   fetch_pc,
  output logic            bubble,
  output logic            slot_kill
);
  logic          cond_taken;
  logic [AW-1:0] slot_pc, after_pc, target_pc, nxt_fetch;
  logic          nxt_bubble, nxt_kill;
  dsb_mode_e     mode;

  assign mode = pick_mode(id_valid && id_is_branch, id_delayed, id_annul);

  dsb_zero_test #(.XLEN(XLEN)) u_test (
    .rs_val(id_rs_val), .test_nz(id_test_nz), .cond_taken(cond_taken)
  );

  dsb_target_add #(.AW(AW), .OFFW(OFFW)) u_add (
    .br_pc(id_pc), .offset(id_offset),
    .slot_pc(slot_pc), .after_pc(after_pc), .target_pc(target_pc)
  );

  dsb_redirect #(.AW(AW)) u_redir (
    .mode(mode), .taken(cond_taken), .pred_taken(id_pred_taken),
    .cur_fetch(fetch_pc), .slot_pc(slot_pc), .after_pc(after_pc),
    .target_pc(target_pc), .nxt_fetch(nxt_fetch),
    .nxt_bubble(nxt_bubble), .nxt_kill(nxt_kill)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_pc  <= RESET_PC;
      bubble    <= 1'b0;
      slot_kill <= 1'b0;
    end else begin
      fetch_pc  <= nxt_fetch;
      bubble    <= nxt_bubble;
      slot_kill <= nxt_kill;
    end
  end

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (fetch_pc == RESET_PC && !bubble && !slot_kill));

  // R2: no live branch, sequential fetch
  a_r2_seq_advance: assert property (@(posedge clk) disable iff (rst)
    (mode == SEQ_NEXT) |=> (fetch_pc == $past(fetch_pc) + AW'(4) && !bubble && !slot_kill));

  // R5: a non-delayed branch costs one bubble
  a_r5_stall_bubble: assert property (@(posedge clk) disable iff (rst)
    (mode == BR_STALL) |=> (bubble && !slot_kill));

  // R6: a plain delayed branch never kills its slot
  a_r6_slot_runs: assert property (@(posedge clk) disable iff (rst)
    (mode == BR_DELAY) |=> (!slot_kill && !bubble));

  // R7: a correct prediction keeps the slot
  a_r7_hit_keeps_slot: assert property (@(posedge clk) disable iff (rst)
    (mode == BR_CANCEL && cond_taken == id_pred_taken) |=> !slot_kill);

  // R9: the two squash outputs are exclusive
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(bubble && slot_kill));
endmodule

// File: tb/dslot_branch_unit_test.sv
`timescale 1ns/1ps
module dslot_branch_unit_test;
  localparam int XLEN = 32, AW = 32, OFFW = 16;
  localparam logic [AW-1:0] RPC = 32'h0000_1000;

  logic clk = 1'b0, rst = 1'b1;
  logic id_valid = 0, id_is_branch = 0, id_test_nz = 0, id_delayed = 0;
  logic id_annul = 0, id_pred_taken = 0;
  logic [XLEN-1:0] id_rs_val = '0;
  logic [AW-1:0]   id_pc = '0;
  logic [OFFW-1:0] id_offset = '0;
  logic [AW-1:0]   fetch_pc;
  logic            bubble, slot_kill;

  int vectors = 0, errors = 0;
  bit done = 0;
  logic [AW-1:0] exp_pc;

  always #4 clk = ~clk;

  dslot_branch_unit #(.XLEN(XLEN), .AW(AW), .OFFW(OFFW), .RESET_PC(RPC)) uut (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_is_branch(id_is_branch),
    .id_test_nz(id_test_nz), .id_delayed(id_delayed), .id_annul(id_annul),
    .id_pred_taken(id_pred_taken), .id_rs_val(id_rs_val), .id_pc(id_pc),
    .id_offset(id_offset), .fetch_pc(fetch_pc), .bubble(bubble), .slot_kill(slot_kill)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: inputs applied at negedge, outputs checked at next negedge
  task automatic step(input logic v, input logic br, input logic nz, input logic dl,
                      input logic an, input logic pr, input logic [XLEN-1:0] rs,
                      input logic [AW-1:0] pc, input logic [OFFW-1:0] off, input string tag);
    logic taken;
    logic [AW-1:0] tgt;
    logic e_bub, e_kill;
    id_valid = v; id_is_branch = br; id_test_nz = nz; id_delayed = dl;
    id_annul = an; id_pred_taken = pr; id_rs_val = rs; id_pc = pc; id_offset = off;
    taken = nz ? (rs != 0) : (rs == 0);                       // R3
    tgt = pc + 32'd4 + ({{(AW-OFFW){off[OFFW-1]}}, off} << 2); // R4
    e_bub = 0; e_kill = 0;
    if (!(v && br)) exp_pc = exp_pc + 32'd4;                   // R2
    else if (!dl) begin exp_pc = taken ? tgt : pc + 32'd4; e_bub = 1; end  // R5, R8
    else begin
      exp_pc = taken ? tgt : pc + 32'd8;                       // R6
      e_kill = an && (taken != pr);                            // R7
    end
    @(negedge clk);
    check({tag, " fetch_pc"}, fetch_pc, exp_pc);
    check({tag, " bubble"}, AW'(bubble), AW'(e_bub));
    check({tag, " slot_kill"}, AW'(slot_kill), AW'(e_kill));
    check("R9 exclusive", AW'(bubble && slot_kill), '0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; vectors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin : main
    logic [XLEN-1:0] rsv [4];
    logic [OFFW-1:0] offv [5];
    rsv[0] = '0; rsv[1] = 1; rsv[2] = '1; rsv[3] = 32'h8000_0000;
    offv[0] = '0; offv[1] = 16'd1; offv[2] = 16'hFFFF; offv[3] = 16'h7FFF; offv[4] = 16'h8000;
    repeat (3) @(negedge clk);
    check("R1 fetch_pc", fetch_pc, RPC);
    check("R1 bubble", AW'(bubble), '0);
    check("R1 slot_kill", AW'(slot_kill), '0);
    rst = 1'b0;
    exp_pc = RPC;
    @(negedge clk);
    exp_pc = RPC + 32'd4;
    check("R1 first cycle", fetch_pc, exp_pc);
    // idle and invalid branches with branch-like inputs
    step(0, 0, 0, 0, 0, 0, '0, 32'h40, 16'h10, "R2 idle");
    step(0, 1, 0, 0, 1, 1, '0, 32'h80, 16'h20, "R2 invalid branch");
    step(1, 0, 1, 1, 1, 0, 32'd5, 32'h90, 16'h30, "R2 non-branch");
    // sweep: 5 mode combos x 2 kinds x 4 values x 5 offsets
    for (int m = 0; m < 5; m++)
      for (int k = 0; k < 2; k++)
        for (int r = 0; r < 4; r++)
          for (int o = 0; o < 5; o++) begin
            logic dl, an, pr;
            string tg;
            case (m)
              0: begin dl = 0; an = 0; pr = 0; tg = "R5 stall"; end
              1: begin dl = 0; an = 1; pr = (o % 2 == 1); tg = "R8 flags ignored"; end
              2: begin dl = 1; an = 0; pr = 1; tg = "R6 delayed"; end
              3: begin dl = 1; an = 1; pr = 1; tg = "R7 cancel pred-taken"; end
              default: begin dl = 1; an = 1; pr = 0; tg = "R7 cancel pred-not"; end
            endcase
            step(1, 1, k[0], dl, an, pr, rsv[r], 32'h0001_0000 + 32'(m * 256 + o * 16),
                 offv[o], $sformatf("%s R3 R4 k%0d r%0d o%0d", tg, k, r, o));
            step(1, 0, 0, 0, 0, 0, '0, '0, '0, "R2 gap");
          end
    // wraparound of the target
    step(1, 1, 0, 1, 0, 0, '0, 32'hFFFF_FFF8, 16'h0004, "R4 wrap");
    rst = 1'b1;
    @(negedge clk);
    check("R1 re-reset", fetch_pc, RPC);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule